// File: doc/BRIEF.md
# Two-Direction Cache Line Pre-Activator

This block decides which drowsy instruction-cache lines to wake before fetch reaches them. It observes the line that fetch is currently on, given as a set and a way, together with a one-cycle pulse that marks the move to a new line. For every line it keeps two learned predictions. The first is a way inside the following set, which is the sequential direction. The second is a complete set-and-way target, which is the taken-branch direction. When predictions are read, the block raises wake requests for the two predicted lines and records them in per-line pre-activation bits. Those bits are cleared again when fetch moves on.

If fetch lands on a line that is neither pre-activated nor held awake by the external keep-awake vector, the block flags a one-cycle wake-up stall and retrains. The miss is classed as sequential when the new set is one above the previous set, wrapping at the top. A sequential miss rewrites the way entry. Any other miss rewrites the full target entry. The entries that are rewritten belong to an earlier line, chosen by the mode.

A mode parameter selects between two timings. In immediate mode, the entries of the line just entered fire on the next cycle. In delayed mode, the entries are latched and fire at the following line change, which removes the late wake-up that occurs when fetch stays on a line for only one cycle.

Top module: `preact_ctrl`

## Requirements
- R1: After reset every pre-activation bit is 0, no wake request is raised and no stall is flagged; every learned entry reads as zero (way 0, set 0).
- R2: The sequential prediction of a base line names set (base set + 1) modulo SETS and the stored way; set SETS-1 wraps to set 0. A line's index is set*WAYS + way, and bit i of each line vector refers to line i.
- R3: The jump prediction of a line names the stored set and way directly.
- R4: In immediate mode the entries of the line entered on a line change are read that cycle, the wake requests for both predicted lines appear in the next cycle only, and the matching pre-activation bits are set at the end of that wake cycle. A line entered one cycle after its predictor is therefore still drowsy.
- R5: On a line change, all pre-activation bits are cleared except those being woken in that same cycle.
- R6: The stall output is high exactly in a line-change cycle whose new line has neither its pre-activation bit nor its keep-awake bit set.
- R7: In immediate mode, a stall retrains the line entered just before. If the new set equals that line's set + 1 (mod SETS), its way entry takes the new way. Otherwise its jump entry takes the new set and way.
- R8: In delayed mode, entries read on a line change are latched and fire on the next line change, in the same cycle. The sequential target is based on the set being entered. Pre-activation bits are set on that edge. A stall retrains the line entered two changes earlier, using the same sequential test against the line entered just before.
- R9: A line whose keep-awake input bit is set is treated as awake and causes no stall.
- R10: No more than two wake request bits are high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_change_i | input | 1 | Pulse: fetch has entered the line on fetch_set_i/fetch_way_i this cycle |
| fetch_set_i | input | SET_W | Set of the line being fetched |
| fetch_way_i | input | WAY_W | Way of the line being fetched |
| keep_awake_i | input | SETS*WAYS | Lines held awake by an external keeper |
| wake_req_o | output | SETS*WAYS | One-cycle wake requests for predicted lines |
| pa_o | output | SETS*WAYS | Pre-activation bit per line |
| stall_o | output | 1 | Missed pre-activation; one wake-up stall cycle |

## Verification
Both modes are driven with a visit order that repeats: a sequential step, a jump, and a return. On the first pass every entry is still zero, so the bench can tell predictions taken from reset contents apart from learned ones. On the second pass the stalls should vanish, which shows that the right entry of the right earlier line was rewritten. In immediate mode, a one-cycle dwell separates late wake-up from a plain miss. Visits that cross the top set exercise the wrap in both the target and the sequential test, and a keep-awake visit shows that an external hold suppresses the stall.

// File: rtl/preact_pkg.sv
package preact_pkg;

    typedef enum logic {
        PREACT_IMMEDIATE = 1'b0,
        PREACT_DELAYED   = 1'b1
    } preact_mode_e;

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/preact_entry_store.sv
module preact_entry_store #(
    parameter int unsigned SETS  = 16,
    parameter int unsigned WAYS  = 4,
    parameter int unsigned SET_W = preact_pkg::width_of(SETS),
    parameter int unsigned WAY_W = preact_pkg::width_of(WAYS),
    parameter int unsigned LINES = SETS * WAYS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set_i,
    input  logic [WAY_W-1:0] rd_way_i,
    output logic [WAY_W-1:0] rd_seq_way_o,
    output logic [SET_W-1:0] rd_jmp_set_o,
    output logic [WAY_W-1:0] rd_jmp_way_o,
    input  logic             wr_seq_i,
    input  logic             wr_jmp_i,
    input  logic [SET_W-1:0] wr_set_i,
    input  logic [WAY_W-1:0] wr_way_i,
    input  logic [SET_W-1:0] new_set_i,
    input  logic [WAY_W-1:0] new_way_i
);
    localparam int unsigned IDX_W  = preact_pkg::width_of(LINES);
    localparam bit          SEQ_EN = (WAYS > 1);

    typedef struct packed {
        logic [WAY_W-1:0] seq_way;
        logic [SET_W-1:0] jmp_set;
        logic [WAY_W-1:0] jmp_way;
    } entry_t;

    typedef struct packed {
        entry_t [LINES-1:0] ent;
    } store_t;

    store_t st_d, st_q;
    logic [IDX_W-1:0] rd_idx, wr_idx;

    assign rd_idx = IDX_W'(rd_set_i) * IDX_W'(WAYS) + IDX_W'(rd_way_i);
    assign wr_idx = IDX_W'(wr_set_i) * IDX_W'(WAYS) + IDX_W'(wr_way_i);

    // With a single way the sequential way is implied, so it reads as zero.
    assign rd_seq_way_o = SEQ_EN ? st_q.ent[rd_idx].seq_way : '0;
    assign rd_jmp_set_o = st_q.ent[rd_idx].jmp_set;
    assign rd_jmp_way_o = st_q.ent[rd_idx].jmp_way;

    always_comb begin
        st_d = st_q;
        if (wr_seq_i && SEQ_EN) begin
            st_d.ent[wr_idx].seq_way = new_way_i;
        end
        if (wr_jmp_i) begin
            st_d.ent[wr_idx].jmp_set = new_set_i;
            st_d.ent[wr_idx].jmp_way = new_way_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/preact_history.sv
module preact_history #(
    parameter int unsigned SET_W = 4,
    parameter int unsigned WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_change_i,
    input  logic [SET_W-1:0] cur_set_i,
    input  logic [WAY_W-1:0] cur_way_i,
    output logic             prev_vld_o,
    output logic [SET_W-1:0] prev_set_o,
    output logic [WAY_W-1:0] prev_way_o,
    output logic             back2_vld_o,
    output logic [SET_W-1:0] back2_set_o,
    output logic [WAY_W-1:0] back2_way_o
);
    typedef struct packed {
        logic             vld;
        logic [SET_W-1:0] set;
        logic [WAY_W-1:0] way;
    } line_ref_t;

    typedef struct packed {
        line_ref_t prev;
        line_ref_t back2;
    } hist_t;

    hist_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (line_change_i) begin
            h_d.back2    = h_q.prev;
            h_d.prev.vld = 1'b1;
            h_d.prev.set = cur_set_i;
            h_d.prev.way = cur_way_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign prev_vld_o  = h_q.prev.vld;
    assign prev_set_o  = h_q.prev.set;
    assign prev_way_o  = h_q.prev.way;
    assign back2_vld_o = h_q.back2.vld;
    assign back2_set_o = h_q.back2.set;
    assign back2_way_o = h_q.back2.way;

endmodule

// File: rtl/preact_wake.sv
module preact_wake #(
    parameter int unsigned SETS  = 16,
    parameter int unsigned WAYS  = 4,
    parameter int unsigned SET_W = preact_pkg::width_of(SETS),
    parameter int unsigned WAY_W = preact_pkg::width_of(WAYS),
    parameter int unsigned LINES = SETS * WAYS,
    parameter preact_pkg::preact_mode_e MODE = preact_pkg::PREACT_IMMEDIATE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_change_i,
    input  logic [SET_W-1:0] cur_set_i,
    input  logic [WAY_W-1:0] rd_seq_way_i,
    input  logic [SET_W-1:0] rd_jmp_set_i,
    input  logic [WAY_W-1:0] rd_jmp_way_i,
    output logic [LINES-1:0] wake_o,
    output logic [LINES-1:0] pa_o
);
    localparam int unsigned IDX_W   = preact_pkg::width_of(LINES);
    localparam bit          DELAYED = (MODE == preact_pkg::PREACT_DELAYED);

    typedef struct packed {
        logic             vld;
        logic [SET_W-1:0] base_set;
        logic [WAY_W-1:0] seq_way;
        logic [SET_W-1:0] jmp_set;
        logic [WAY_W-1:0] jmp_way;
    } pend_t;

    typedef struct packed {
        pend_t            pend;
        logic [LINES-1:0] pa;
    } wake_st_t;

    wake_st_t st_d, st_q;

    logic             fire;
    logic [SET_W-1:0] base_set, seq_set;
    logic [IDX_W-1:0] seq_idx, jmp_idx;
    logic [LINES-1:0] wake_vec;

    // Immediate: predictions read last cycle fire now, based on the line read.
    // Delayed: latched predictions fire on the change, based on the line entered.
    assign fire     = DELAYED ? (line_change_i && st_q.pend.vld) : st_q.pend.vld;
    assign base_set = DELAYED ? cur_set_i : st_q.pend.base_set;
    assign seq_set  = (base_set == SET_W'(SETS - 1)) ? '0 : base_set + SET_W'(1);
    assign seq_idx  = IDX_W'(seq_set) * IDX_W'(WAYS) + IDX_W'(st_q.pend.seq_way);
    assign jmp_idx  = IDX_W'(st_q.pend.jmp_set) * IDX_W'(WAYS) + IDX_W'(st_q.pend.jmp_way);

    always_comb begin
        wake_vec = '0;
        if (fire) begin
            wake_vec = (LINES'(1) << seq_idx) | (LINES'(1) << jmp_idx);
        end
    end

    always_comb begin
        st_d = st_q;
        if (!DELAYED) begin
            st_d.pend.vld = line_change_i;
        end else if (line_change_i) begin
            st_d.pend.vld = 1'b1;
        end
        if (line_change_i) begin
            st_d.pend.base_set = cur_set_i;
            st_d.pend.seq_way  = rd_seq_way_i;
            st_d.pend.jmp_set  = rd_jmp_set_i;
            st_d.pend.jmp_way  = rd_jmp_way_i;
            st_d.pa            = wake_vec;
        end else begin
            st_d.pa            = st_q.pa | wake_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wake_o = wake_vec;
    assign pa_o   = st_q.pa;

endmodule

// File: rtl/preact_ctrl.sv
module preact_ctrl #(
    parameter int unsigned SETS = 16,
    parameter int unsigned WAYS = 4,
    parameter preact_pkg::preact_mode_e MODE = preact_pkg::PREACT_IMMEDIATE,
    parameter int unsigned SET_W = preact_pkg::width_of(SETS),
    parameter int unsigned WAY_W = preact_pkg::width_of(WAYS),
    parameter int unsigned LINES = SETS * WAYS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_change_i,
    input  logic [SET_W-1:0] fetch_set_i,
    input  logic [WAY_W-1:0] fetch_way_i,
    input  logic [LINES-1:0] keep_awake_i,
    output logic [LINES-1:0] wake_req_o,
    output logic [LINES-1:0] pa_o,
    output logic             stall_o
);
    localparam int unsigned IDX_W   = preact_pkg::width_of(LINES);
    localparam bit          DELAYED = (MODE == preact_pkg::PREACT_DELAYED);

    logic [WAY_W-1:0] rd_seq_way, rd_jmp_way;
    logic [SET_W-1:0] rd_jmp_set;
    logic             prev_vld, back2_vld;
    logic [SET_W-1:0] prev_set, back2_set, prev_next_set;
    logic [WAY_W-1:0] prev_way, back2_way;
    logic             tgt_vld;
    logic [SET_W-1:0] tgt_set;
    logic [WAY_W-1:0] tgt_way;
    logic [IDX_W-1:0] cur_idx;
    logic [LINES-1:0] awake_vec;
    logic             miss, seq_step, wr_seq, wr_jmp;

    preact_entry_store #(
        .SETS (SETS),
        .WAYS (WAYS),
        .SET_W(SET_W),
        .WAY_W(WAY_W),
        .LINES(LINES)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_set_i    (fetch_set_i),
        .rd_way_i    (fetch_way_i),
        .rd_seq_way_o(rd_seq_way),
        .rd_jmp_set_o(rd_jmp_set),
        .rd_jmp_way_o(rd_jmp_way),
        .wr_seq_i    (wr_seq),
        .wr_jmp_i    (wr_jmp),
        .wr_set_i    (tgt_set),
        .wr_way_i    (tgt_way),
        .new_set_i   (fetch_set_i),
        .new_way_i   (fetch_way_i)
    );

    preact_history #(
        .SET_W(SET_W),
        .WAY_W(WAY_W)
    ) u_hist (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_change_i(line_change_i),
        .cur_set_i    (fetch_set_i),
        .cur_way_i    (fetch_way_i),
        .prev_vld_o   (prev_vld),
        .prev_set_o   (prev_set),
        .prev_way_o   (prev_way),
        .back2_vld_o  (back2_vld),
        .back2_set_o  (back2_set),
        .back2_way_o  (back2_way)
    );

    preact_wake #(
        .SETS (SETS),
        .WAYS (WAYS),
        .SET_W(SET_W),
        .WAY_W(WAY_W),
        .LINES(LINES),
        .MODE (MODE)
    ) u_wake (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_change_i(line_change_i),
        .cur_set_i    (fetch_set_i),
        .rd_seq_way_i (rd_seq_way),
        .rd_jmp_set_i (rd_jmp_set),
        .rd_jmp_way_i (rd_jmp_way),
        .wake_o       (wake_req_o),
        .pa_o         (pa_o)
    );

    assign cur_idx   = IDX_W'(fetch_set_i) * IDX_W'(WAYS) + IDX_W'(fetch_way_i);
    assign awake_vec = pa_o | keep_awake_i;
    assign miss      = line_change_i && !awake_vec[cur_idx];

    // The line whose entries predicted the current one.
    assign tgt_vld = DELAYED ? back2_vld : prev_vld;
    assign tgt_set = DELAYED ? back2_set : prev_set;
    assign tgt_way = DELAYED ? back2_way : prev_way;

    assign prev_next_set = (prev_set == SET_W'(SETS - 1)) ? '0 : prev_set + SET_W'(1);
    assign seq_step      = prev_vld && (fetch_set_i == prev_next_set);

    assign wr_seq  = miss && tgt_vld && seq_step;
    assign wr_jmp  = miss && tgt_vld && !seq_step;
    assign stall_o = miss;

endmodule

// File: rtl/preact_ctrl_checker.sv
module preact_ctrl_checker #(
    parameter int unsigned SETS = 16,
    parameter int unsigned WAYS = 4,
    parameter preact_pkg::preact_mode_e MODE = preact_pkg::PREACT_IMMEDIATE,
    parameter int unsigned SET_W = preact_pkg::width_of(SETS),
    parameter int unsigned WAY_W = preact_pkg::width_of(WAYS),
    parameter int unsigned LINES = SETS * WAYS
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_change_i,
    input logic [SET_W-1:0] fetch_set_i,
    input logic [WAY_W-1:0] fetch_way_i,
    input logic [LINES-1:0] keep_awake_i,
    input logic [LINES-1:0] wake_req_o,
    input logic [LINES-1:0] pa_o,
    input logic             stall_o
);
    localparam int unsigned IDX_W = preact_pkg::width_of(LINES);

    logic [IDX_W-1:0] chk_idx;
    logic [LINES-1:0] chk_awake;

    assign chk_idx   = IDX_W'(fetch_set_i) * IDX_W'(WAYS) + IDX_W'(fetch_way_i);
    assign chk_awake = pa_o | keep_awake_i;

    assert_wake_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wake_req_o) <= 2);

    assert_pa_from_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pa_o & ~$past(pa_o) & ~$past(wake_req_o)) == '0));

    assert_clear_on_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_change_i |=> ((pa_o & ~$past(wake_req_o)) == '0));

    assert_stall_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> line_change_i);

    assert_awake_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_change_i && chk_awake[chk_idx]) |-> !stall_o);

    generate
        if (MODE == preact_pkg::PREACT_DELAYED) begin : g_del
            assert_wake_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (wake_req_o != '0) |-> line_change_i);
        end else begin : g_imm
            assert_wake_after_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (wake_req_o != '0) |-> $past(line_change_i));
        end
    endgenerate

endmodule

bind preact_ctrl preact_ctrl_checker #(
    .SETS (SETS),
    .WAYS (WAYS),
    .MODE (MODE),
    .SET_W(SET_W),
    .WAY_W(WAY_W),
    .LINES(LINES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_change_i(line_change_i),
    .fetch_set_i  (fetch_set_i),
    .fetch_way_i  (fetch_way_i),
    .keep_awake_i (keep_awake_i),
    .wake_req_o   (wake_req_o),
    .pa_o         (pa_o),
    .stall_o      (stall_o)
);

// File: tb/preact_ctrl_test.sv
module preact_ctrl_test;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic        lc_i = 1'b0, lc_d = 1'b0;
    logic [3:0]  fs_i = '0, fs_d = '0;
    logic [1:0]  fw_i = '0, fw_d = '0;
    logic [63:0] keep_i = '0, keep_d = '0;
    logic [63:0] wake_i, wake_d, pa_i, pa_d;
    logic        stall_i, stall_d;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD / 2) clk = ~clk;

    preact_ctrl #(.SETS(16), .WAYS(4), .MODE(preact_pkg::PREACT_IMMEDIATE)) uut (
        .clk(clk), .rst_n(rst_n), .line_change_i(lc_i), .fetch_set_i(fs_i),
        .fetch_way_i(fw_i), .keep_awake_i(keep_i), .wake_req_o(wake_i),
        .pa_o(pa_i), .stall_o(stall_i)
    );

    preact_ctrl #(.SETS(16), .WAYS(4), .MODE(preact_pkg::PREACT_DELAYED)) uut_d (
        .clk(clk), .rst_n(rst_n), .line_change_i(lc_d), .fetch_set_i(fs_d),
        .fetch_way_i(fw_d), .keep_awake_i(keep_d), .wake_req_o(wake_d),
        .pa_o(pa_d), .stall_o(stall_d)
    );

    function automatic logic [63:0] ln(input int s, input int w);
        return 64'd1 << (s * 4 + w);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step_imm(input logic lc, input int s, input int w);
        @(negedge clk);
        lc_i = lc; fs_i = 4'(s); fw_i = 2'(w);
        #1;
    endtask

    task automatic step_del(input logic lc, input int s, input int w);
        @(negedge clk);
        lc_d = lc; fs_d = 4'(s); fw_d = 2'(w);
        #1;
    endtask

    task automatic test_reset();
        step_imm(1'b0, 0, 0);
        step_del(1'b0, 0, 0);
        check("R1", "imm pa", pa_i, '0);
        check("R1", "imm wake", wake_i, '0);
        check("R1", "imm stall", 64'(stall_i), 64'd0);
        check("R1", "del pa", pa_d, '0);
        check("R1", "del stall", 64'(stall_d), 64'd0);
    endtask

    task automatic test_imm_first_pass();
        step_imm(1'b1, 2, 1);
        check("R6", "first access stall", 64'(stall_i), 64'd1);
        step_imm(1'b0, 2, 1);
        check("R4", "wake one cycle after change", wake_i, ln(3, 0) | ln(0, 0));
        step_imm(1'b0, 2, 1);
        check("R4", "pa after wake", pa_i, ln(3, 0) | ln(0, 0));
        check("R4", "wake is one cycle", wake_i, '0);
        step_imm(1'b1, 3, 2);
        check("R6", "sequential miss stall", 64'(stall_i), 64'd1);
        step_imm(1'b0, 3, 2);
        check("R5", "pa cleared on change", pa_i, '0);
        check("R2", "zero entry seq target", wake_i, ln(4, 0) | ln(0, 0));
        step_imm(1'b0, 3, 2);
        step_imm(1'b1, 9, 3);
        check("R6", "jump miss stall", 64'(stall_i), 64'd1);
        step_imm(1'b0, 9, 3);
        step_imm(1'b0, 9, 3);
    endtask

    task automatic test_imm_learned();
        step_imm(1'b1, 2, 1);
        check("R6", "return miss stall", 64'(stall_i), 64'd1);
        step_imm(1'b0, 2, 1);
        check("R7", "learned way entry", wake_i, ln(3, 2) | ln(0, 0));
        step_imm(1'b0, 2, 1);
        step_imm(1'b1, 3, 2);
        check("R7", "sequential line pre-activated", 64'(stall_i), 64'd0);
        step_imm(1'b0, 3, 2);
        check("R3", "learned jump entry", wake_i, ln(4, 0) | ln(9, 3));
        step_imm(1'b0, 3, 2);
        step_imm(1'b1, 9, 3);
        check("R3", "jump line pre-activated", 64'(stall_i), 64'd0);
        step_imm(1'b0, 9, 3);
        check("R7", "jump learned for return", wake_i, ln(10, 0) | ln(2, 1));
        step_imm(1'b0, 9, 3);
    endtask

    task automatic test_imm_late();
        step_imm(1'b1, 2, 1);
        check("R7", "return predicted by jump", 64'(stall_i), 64'd0);
        step_imm(1'b1, 3, 2);
        check("R4", "one-cycle dwell is late", 64'(stall_i), 64'd1);
        check("R10", "late wake pair", wake_i, ln(3, 2) | ln(0, 0));
        step_imm(1'b0, 3, 2);
        check("R5", "pa keeps bits woken at change", pa_i, ln(3, 2) | ln(0, 0));
        step_imm(1'b0, 3, 2);
    endtask

    task automatic test_imm_keep();
        keep_i = ln(12, 0);
        step_imm(1'b1, 12, 0);
        check("R9", "keep-awake line no stall", 64'(stall_i), 64'd0);
        step_imm(1'b0, 12, 0);
        keep_i = '0;
        step_imm(1'b0, 12, 0);
    endtask

    task automatic test_imm_wrap();
        step_imm(1'b1, 15, 1);
        check("R6", "top set miss", 64'(stall_i), 64'd1);
        step_imm(1'b0, 15, 1);
        check("R2", "seq target wraps to set 0", wake_i, ln(0, 0));
        step_imm(1'b1, 0, 3);
        check("R6", "wrapped miss", 64'(stall_i), 64'd1);
        step_imm(1'b0, 0, 3);
        step_imm(1'b1, 15, 1);
        step_imm(1'b0, 15, 1);
        check("R7", "wrap classed sequential", wake_i, ln(0, 3) | ln(0, 0));
        step_imm(1'b0, 15, 1);
    endtask

    task automatic test_delayed();
        step_del(1'b1, 2, 1);
        check("R8", "no latch yet", wake_d, '0);
        check("R6", "del first stall", 64'(stall_d), 64'd1);
        step_del(1'b0, 2, 1);
        step_del(1'b1, 3, 2);
        check("R8", "latched wake at change", wake_d, ln(4, 0) | ln(0, 0));
        step_del(1'b0, 3, 2);
        check("R8", "pa set at change edge", pa_d, ln(4, 0) | ln(0, 0));
        step_del(1'b1, 4, 1);
        check("R6", "del miss", 64'(stall_d), 64'd1);
        step_del(1'b0, 4, 1);
        check("R5", "del pa cleared", pa_d, ln(5, 0) | ln(0, 0));
        step_del(1'b1, 9, 3);
        step_del(1'b0, 9, 3);
        step_del(1'b1, 2, 1);
        check("R8", "wake based on entered set", wake_d, ln(3, 0) | ln(0, 0));
        step_del(1'b1, 3, 2);
        check("R8", "way learned two back", wake_d, ln(4, 1) | ln(0, 0));
        step_del(1'b1, 4, 1);
        check("R8", "no stall after learning", 64'(stall_d), 64'd0);
        check("R8", "jump learned two back", wake_d, ln(5, 0) | ln(9, 3));
        step_del(1'b1, 9, 3);
        check("R8", "jump target awake", 64'(stall_d), 64'd0);
        step_del(1'b0, 9, 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_imm_first_pass();
        test_imm_learned();
        test_imm_late();
        test_imm_keep();
        test_imm_wrap();
        test_delayed();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule